// File: doc/BRIEF.md
# I/O-Mapped Port Decoder with Switch Input and Display Latch

This block sits on the bus of an 8-bit microprocessor. It turns I/O-mapped accesses into selects for two ports. It watches the low address byte, the status line that tells I/O cycles from memory cycles, and the active-low read and write strobes. From these it forms active-low I/O read and I/O write strobes.

The address byte is split in two. The low three bits feed a 3-to-8 decoder. The high five bits form the decoder enable, which is open only for the base pattern: bit 7 set and bits 6 to 3 clear. Select 0 (address 80h) is the input port. While it is selected during an I/O read, it puts the switch byte on the data bus through an explicit output enable. Select 1 (address 81h) is the output port. A latch takes the write data and holds it for a display.

The latch is clocked. It takes the bus data while a selected I/O write is active and updates the display on the clock edge after the write strobe returns high.

Top module: `io_port_decode_top`

## Requirements
- R1: `iord_n` is low exactly when `io_mem`=1 and `rd_n`=0. `iowr_n` is low exactly when `io_mem`=1 and `wr_n`=0. Both are combinational.
- R2: `sel_n[k]` is low exactly when `addr[7:3]`=5'b10000 and `addr[2:0]`=k. At most one bit of `sel_n` is low at any time.
- R3: any other value of `addr[7:3]` keeps all eight `sel_n` bits high.
- R4: `rdata_oe` is 1 exactly when `sel_n[0]` is low and `iord_n` is low. While it is 1, `rdata` equals `sw_in`. At all other times `rdata` is 00h.
- R5: a write counts as selected while `iowr_n` is low and `sel_n[1]` is low. At each such clock edge the latch captures `wdata`. On the first clock edge where that condition no longer holds, `disp` takes the value captured in the last selected cycle.
- R6: a synchronous active-high `rst` sets `disp` to 00h on the next clock edge.
- R7: a memory cycle (`io_mem`=0) raises neither strobe and never sets `rdata_oe`, even at addresses 80h or 81h. `disp` keeps its value through such a cycle.
- R8: I/O writes to any address other than 81h leave `disp` unchanged. I/O reads at any address other than 80h keep `rdata_oe` at 0.
- R9: a display update (the end of a write to 81h) and a read of 80h that starts in the same cycle do not disturb each other. `disp` takes the written value, and the read returns `sw_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Low address byte (port number) |
| io_mem | input | 1 | Cycle status: 1 = I/O, 0 = memory |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| wdata | input | 8 | Data bus value driven by the processor |
| sw_in | input | 8 | Switch inputs for port 80h |
| iord_n | output | 1 | Derived I/O read strobe, active low |
| iowr_n | output | 1 | Derived I/O write strobe, active low |
| sel_n | output | 8 | Decoder outputs, active low |
| rdata | output | 8 | Data returned to the bus |
| rdata_oe | output | 1 | Bus drive enable for the input buffer |
| disp | output | 8 | Latched display value for port 81h |

## Verification
A latch commit and an input-port read can land in the same cycle. This happens when a write to 81h ends and, in the very cycle the write strobe rises, the address moves to 80h with the read strobe low. The bench sets up exactly that handover. In that one cycle it checks that the read enable and switch data are already on the bus. After the following edge it checks that the display holds the written byte. Separately, it sweeps all 256 addresses in both I/O and memory cycles, for reads and for writes, and compares against a model it computes itself.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

    typedef enum logic {
        CYC_MEM = 1'b0,
        CYC_IO  = 1'b1
    } cyc_kind_e;

    function automatic logic strobe_active_n(input logic kind, input logic cpu_n);
        return !((kind == CYC_IO) && !cpu_n);
    endfunction

endpackage

// File: rtl/io_strobe_gen.sv
module io_strobe_gen
    import io_dec_pkg::*;
(
    input  logic io_mem,
    input  logic rd_n,
    input  logic wr_n,
    output logic iord_n,
    output logic iowr_n
);
    always_comb begin
        iord_n = strobe_active_n(io_mem, rd_n);
        iowr_n = strobe_active_n(io_mem, wr_n);
    end
endmodule

// File: rtl/io_addr_decoder.sv
module io_addr_decoder #(
    parameter int ADDR_W    = 8,
    parameter int SEL_W     = 3,
    parameter int BASE_ADDR = 'h80,
    localparam int NUM_SEL  = 1 << SEL_W,
    localparam int HI_W     = ADDR_W - SEL_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SEL-1:0] sel_n
);
    localparam logic [HI_W-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:SEL_W];

    logic            dec_en;
    logic [SEL_W-1:0] dec_lo;

    always_comb begin
        dec_en = (addr[ADDR_W-1:SEL_W] == BASE_HI);
        dec_lo = addr[SEL_W-1:0];
    end

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_out
        always_comb sel_n[k] = !(dec_en && (dec_lo == SEL_W'(k)));
    end
endmodule

// File: rtl/io_in_buffer.sv
module io_in_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              sel_in_n,
    input  logic              iord_n,
    input  logic [DATA_W-1:0] sw_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    always_comb begin
        rdata_oe = !sel_in_n && !iord_n;
        rdata    = rdata_oe ? sw_in : '0;
    end
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_out_n,
    input  logic              iowr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] disp
);
    typedef struct packed {
        logic              act;
        logic [DATA_W-1:0] cap;
        logic [DATA_W-1:0] disp;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit       = !iowr_n && !sel_out_n;
        st_d      = st_q;
        st_d.act  = hit;
        if (hit)
            st_d.cap = wdata;
        if (st_q.act && !hit)
            st_d.disp = st_q.cap;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb disp = st_q.disp;

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !st_q.act |=> $stable(disp)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (disp == '0)); // R6
endmodule

// File: rtl/io_port_decode_top.sv
module io_port_decode_top #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SEL_W     = 3,
    parameter int BASE_ADDR = 'h80,
    parameter int IN_IDX    = 0,
    parameter int OUT_IDX   = 1,
    localparam int NUM_SEL  = 1 << SEL_W,
    localparam int HI_W     = ADDR_W - SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               io_mem,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  sw_in,
    output logic               iord_n,
    output logic               iowr_n,
    output logic [NUM_SEL-1:0] sel_n,
    output logic [DATA_W-1:0]  rdata,
    output logic               rdata_oe,
    output logic [DATA_W-1:0]  disp
);
    localparam logic [HI_W-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:SEL_W];

    io_strobe_gen u_strobe (
        .io_mem (io_mem),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .iord_n (iord_n),
        .iowr_n (iowr_n)
    );

    io_addr_decoder #(
        .ADDR_W    (ADDR_W),
        .SEL_W     (SEL_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr  (addr),
        .sel_n (sel_n)
    );

    io_in_buffer #(.DATA_W(DATA_W)) u_inbuf (
        .sel_in_n (sel_n[IN_IDX]),
        .iord_n   (iord_n),
        .sw_in    (sw_in),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    io_out_latch #(.DATA_W(DATA_W)) u_outlat (
        .clk       (clk),
        .rst       (rst),
        .sel_out_n (sel_n[OUT_IDX]),
        .iowr_n    (iowr_n),
        .wdata     (wdata),
        .disp      (disp)
    );

    AST_MEM_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !io_mem |-> (iord_n && iowr_n && !rdata_oe)); // R7
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones(~sel_n) <= 1); // R2
    AST_UPPER_MISS: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1:SEL_W] != BASE_HI) |-> (&sel_n)); // R3
    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> (!rd_n && io_mem && !sel_n[IN_IDX])); // R4
    AST_MEM_DISP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!io_mem && $past(!io_mem) && !$past(rst)) |=> $stable(disp)); // R7
endmodule

// File: tb/sim_io_port_decode_top.sv
`timescale 1ns/1ps
module sim_io_port_decode_top;
    localparam time CYC = 20ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       io_mem = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] sw_in = 8'h00;
    logic       iord_n, iowr_n, rdata_oe;
    logic [7:0] sel_n, rdata, disp;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] exp_disp = 8'h00;

    always #(CYC/2) clk = ~clk;

    io_port_decode_top u0 (
        .clk(clk), .rst(rst), .addr(addr), .io_mem(io_mem), .rd_n(rd_n),
        .wr_n(wr_n), .wdata(wdata), .sw_in(sw_in), .iord_n(iord_n),
        .iowr_n(iowr_n), .sel_n(sel_n), .rdata(rdata), .rdata_oe(rdata_oe),
        .disp(disp)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sel(input logic [7:0] a);
        logic [7:0] s = 8'hFF;
        if (a[7:3] == 5'b10000) s[a[2:0]] = 1'b0;
        return s;
    endfunction

    // one I/O or memory write: strobe low for one edge, then high for one edge
    task automatic do_write(input logic [7:0] a, input logic io, input logic [7:0] d);
        @(negedge clk);
        addr = a; io_mem = io; wdata = d; wr_n = 1'b0; rd_n = 1'b1;
        #2;
        chk(iowr_n == !io, "R1 iowr_n", iowr_n, !io);
        chk(iord_n == 1'b1, "R1 iord_n idle", iord_n, 1);
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        if (io && a == 8'h81) exp_disp = d;
        #2;
        if (io && a == 8'h81) chk(disp == exp_disp, "R5 disp load", disp, exp_disp);
        else if (!io)         chk(disp == exp_disp, "R7 disp mem", disp, exp_disp);
        else                  chk(disp == exp_disp, "R8 disp other", disp, exp_disp);
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(disp == 8'h00, "R6 reset", disp, 0);
        chk(sel_n == 8'hFF, "R3 addr 00", sel_n, 8'hFF);
        @(negedge clk);
        rst = 1'b0;

        // read sweep: every address, both cycle kinds
        for (int io = 0; io < 2; io++) begin
            for (int a = 0; a < 256; a++) begin
                @(negedge clk);
                addr = 8'(a); io_mem = 1'(io); rd_n = 1'b0; wr_n = 1'b1;
                sw_in = 8'(a) ^ 8'h5A;
                #2;
                chk(iord_n == !1'(io), "R1 iord_n", iord_n, !1'(io));
                chk(iowr_n == 1'b1, "R1 iowr_n idle", iowr_n, 1);
                chk(sel_n == exp_sel(8'(a)),
                    (a[7:3] == 5'b10000) ? "R2 sel" : "R3 sel", sel_n, exp_sel(8'(a)));
                if (io == 1 && a == 'h80) begin
                    chk(rdata_oe == 1'b1, "R4 oe", rdata_oe, 1);
                    chk(rdata == sw_in, "R4 rdata", rdata, sw_in);
                end else begin
                    chk(rdata_oe == 1'b0, io == 0 ? "R7 oe" : "R8 oe", rdata_oe, 0);
                    chk(rdata == 8'h00, "R4 rdata idle", rdata, 0);
                end
            end
        end
        @(negedge clk);
        rd_n = 1'b1;
        #2;
        chk(rdata_oe == 1'b0, "R4 oe no strobe", rdata_oe, 0);

        // write sweep
        do_write(8'h81, 1'b1, 8'hC3);
        for (int io = 0; io < 2; io++)
            for (int a = 0; a < 256; a++)
                do_write(8'(a), 1'(io), 8'(a) + 8'h33);
        do_write(8'h81, 1'b0, 8'h11);
        do_write(8'h82, 1'b1, 8'h22);
        do_write(8'h87, 1'b1, 8'h23);
        do_write(8'hC1, 1'b1, 8'h24);
        do_write(8'h01, 1'b1, 8'h25);

        // R9: write to 81h ends in the cycle a read of 80h begins
        @(negedge clk);
        addr = 8'h81; io_mem = 1'b1; wdata = 8'hA5; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; addr = 8'h80; rd_n = 1'b0; sw_in = 8'h3C;
        #2;
        chk(rdata_oe == 1'b1, "R9 oe", rdata_oe, 1);
        chk(rdata == 8'h3C, "R9 rdata", rdata, 8'h3C);
        @(negedge clk);
        #2;
        chk(disp == 8'hA5, "R9 disp", disp, 8'hA5);
        chk(rdata == 8'h3C, "R9 rdata hold", rdata, 8'h3C);
        rd_n = 1'b1;

        // R6: reset after a load
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #2;
        chk(disp == 8'h00, "R6 reset clears", disp, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule